// File: doc/BRIEF.md
# Chunked Control Mailbox

A device-side register block through which a host issues control commands and collects multi-word responses. The host sees a small 32-bit register space: a command word (opcode and queue index), a control/status word, and a window of data words that holds exactly one chunk. A stub response source inside the block stands in for the device logic. It produces response words for the read-queue-state command, produces nothing for the commands that carry no payload, and produces error codes for bad requests.

To run a command, the host writes the wanted response length (in words) to the control word and then writes a nonzero opcode. The block loads the data window one chunk at a time. It raises chunk-ready and waits until the host writes the control word back with chunk-ready cleared, and only then loads the next chunk. On the final chunk it drops in-process together with raising chunk-ready and clears the command word. In legacy mode only the command word is used: the block takes the opcode and acknowledges it by clearing the register one cycle later.

Register map (host word address): 0 command word, 1 control word, 2 reserved (reads zero), 3 onward data window slots 0 to ChunkWords-1. All other addresses read zero.

Top module: `chunk_mailbox`

## Requirements
- R1: After reset the command word, the control word and every data window slot read zero.
- R2: In idle, with legacy mode off, a write to address 0 whose bits 15:0 (opcode; 1 destroy, 2 read queue state, 3 suspend, 4 resume) are nonzero starts a command. On the next cycle the command word reads back the written value (queue index in bits 31:16) and the control word shows in-process (bit 16) set, chunk-ready (bit 17) clear and error (bits 27:18) zero. While idle, a control-word write stores bits 15:0 as the requested length and clears the flags and the error field.
- R3: One cycle after the start, or after an acknowledge, the block loads a chunk for read queue state. The size field (bits 15:0) is min(remaining, ChunkWords), chunk-ready is set, window slot i holds {queue index, 16'hA000 + k} for response word k, and the slots past the chunk size read zero. The size field never exceeds ChunkWords, and the reserved address reads zero.
- R4: Writing the control word with bit 17 clear while a chunk is pending clears chunk-ready on the next cycle, and the next chunk follows one cycle later. A control write with bit 17 set is ignored.
- R5: On the final chunk, in-process clears and the command word reads zero in the same cycle that chunk-ready rises.
- R6: The sizes of all the chunks of a read-queue-state command add up to min(requested length, RespWords).
- R7: Opcodes 1, 3 and 4 are acknowledged with chunk-ready set, size zero and in-process set. After the host acknowledges, the command word, in-process and chunk-ready all read zero.
- R8: An opcode above 4 sets error code 1, and read queue state with a queue index of NumQueues or more sets error code 2. In either case in-process, chunk-ready and the command word are zero. A nonzero error field is never seen with in-process or chunk-ready set.
- R9: A write of a nonzero opcode while a command is active leaves the command word unchanged.
- R10: A write to address 0 with bits 15:0 zero while a command is active aborts it. On the next cycle the command word, in-process and chunk-ready are zero.
- R11: In legacy mode a nonzero opcode write is held for one cycle and then the command word clears to zero. The control word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| legacyMode | input | 1 | Single-register acknowledge mode, sampled when a command starts |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | AddrW | Host word address for reads and writes |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Read data for hostAddr (combinational) |

## Verification
Read queue state is swept over every valid queue index and over requested lengths from zero to above the response length. This covers requests that end inside the first chunk, exactly on a chunk boundary, across two chunks, and requests clipped by the response length. The sweep therefore separates the size arithmetic, the placement of words in the window and the final-chunk flag timing. The payload-free opcodes, the two error causes, an ignored acknowledge, an ignored mid-command opcode, an abort and a legacy command are each run once, and each checks the registers that the stimulus could have disturbed.

// File: rtl/chunk_mailbox_pkg.sv
package chunk_mailbox_pkg;
  localparam logic [15:0] OP_DESTROY = 16'd1;
  localparam logic [15:0] OP_READQ   = 16'd2;
  localparam logic [15:0] OP_SUSPEND = 16'd3;
  localparam logic [15:0] OP_RESUME  = 16'd4;

  localparam int BIT_INPROC = 16;
  localparam int BIT_READY  = 17;

  localparam logic [9:0] ERR_BADOP = 10'd1;
  localparam logic [9:0] ERR_BADQ  = 10'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_LEGACY} mbState_t;

  typedef struct packed {
    logic start;
    logic legStart;
    logic setLen;
    logic chunk;
    logic lastChunk;
    logic ackOnly;
    logic ackChunk;
    logic finish;
    logic fail;
    logic abort;
    logic legDone;
  } mbStrobe_t;
endpackage

// File: rtl/mailbox_ctrl.sv
module mailbox_ctrl
  import chunk_mailbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrOp,
  input  logic        wrCtrl,
  input  logic [31:0] wrData,
  input  logic        legacyMode,
  input  logic        errPending,
  input  logic        noPayload,
  input  logic        finalChunk,
  output mbStrobe_t   strobe
);
  mbState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (state == ST_IDLE) begin
      if (wrOp && wrData[15:0] != 16'd0) begin
        if (legacyMode) begin
          strobe.legStart = 1'b1;
          nextState       = ST_LEGACY;
        end else begin
          strobe.start = 1'b1;
          nextState    = ST_LOAD;
        end
      end else if (wrCtrl) begin
        strobe.setLen = 1'b1;
      end
    end else if (wrOp && wrData[15:0] == 16'd0) begin
      strobe.abort = 1'b1;
      nextState    = ST_IDLE;
    end else begin
      case (state)
        ST_LOAD: begin
          if (errPending) begin
            strobe.fail = 1'b1;
            nextState   = ST_IDLE;
          end else if (noPayload) begin
            strobe.ackOnly = 1'b1;
            nextState      = ST_WAIT;
          end else if (finalChunk) begin
            strobe.lastChunk = 1'b1;
            nextState        = ST_IDLE;
          end else begin
            strobe.chunk = 1'b1;
            nextState    = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wrCtrl && !wrData[BIT_READY]) begin
            if (noPayload) begin
              strobe.finish = 1'b1;
              nextState     = ST_IDLE;
            end else begin
              strobe.ackChunk = 1'b1;
              nextState       = ST_LOAD;
            end
          end
        end
        ST_LEGACY: begin
          strobe.legDone = 1'b1;
          nextState      = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/mailbox_datapath.sv
module mailbox_datapath
  import chunk_mailbox_pkg::*;
#(
  parameter int ChunkWords = 4,
  parameter int RespWords  = 6,
  parameter int NumQueues  = 4,
  parameter int AddrW      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbStrobe_t        strobe,
  input  logic [31:0]      wrData,
  input  logic [AddrW-1:0] rdAddr,
  output logic [31:0]      rdData,
  output logic [31:0]      opWord,
  output logic [31:0]      ctrlWord,
  output logic             errPending,
  output logic             noPayload,
  output logic             finalChunk
);
  localparam int WinBase = 3;
  localparam logic [15:0] ChunkLen = 16'(ChunkWords);
  localparam logic [15:0] RespLen  = 16'(RespWords);

  logic [31:0] opReg;
  logic [15:0] sizeF, reqLen, sent;
  logic        inProc, chunkRdy;
  logic [9:0]  errF;
  logic [31:0] win      [ChunkWords];
  logic [31:0] slotNext [ChunkWords];

  logic [15:0] opcode, qIdx, availW, total, remain, nThis;
  logic [9:0]  errCode;

  assign opcode = opReg[15:0];
  assign qIdx   = opReg[31:16];
  assign availW = (opcode == OP_READQ) ? RespLen : 16'd0;
  assign total  = (reqLen < availW) ? reqLen : availW;
  assign remain = total - sent;
  assign nThis  = (remain < ChunkLen) ? remain : ChunkLen;

  always_comb begin
    if (opcode == 16'd0 || opcode > OP_RESUME)               errCode = ERR_BADOP;
    else if (opcode == OP_READQ && qIdx >= 16'(NumQueues))   errCode = ERR_BADQ;
    else                                                     errCode = 10'd0;
  end

  assign errPending = errCode != 10'd0;
  assign noPayload  = opcode != OP_READQ;
  assign finalChunk = remain <= ChunkLen;

  for (genvar i = 0; i < ChunkWords; i++) begin : gSlot
    assign slotNext[i] = (16'(i) < nThis) ? {qIdx, 16'hA000 + sent + 16'(i)} : 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < ChunkWords; k++) win[k] <= '0;
    end else if (strobe.chunk || strobe.lastChunk) begin
      for (int k = 0; k < ChunkWords; k++) win[k] <= slotNext[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg    <= '0;
      sizeF    <= '0;
      reqLen   <= '0;
      sent     <= '0;
      inProc   <= 1'b0;
      chunkRdy <= 1'b0;
      errF     <= '0;
    end else if (strobe.start) begin
      opReg    <= wrData;
      reqLen   <= sizeF;
      sent     <= '0;
      inProc   <= 1'b1;
      chunkRdy <= 1'b0;
      errF     <= '0;
    end else if (strobe.legStart) begin
      opReg <= wrData;
    end else if (strobe.setLen) begin
      sizeF    <= wrData[15:0];
      inProc   <= 1'b0;
      chunkRdy <= 1'b0;
      errF     <= '0;
    end else if (strobe.chunk || strobe.lastChunk) begin
      sizeF    <= nThis;
      sent     <= sent + nThis;
      chunkRdy <= 1'b1;
      if (strobe.lastChunk) begin
        inProc <= 1'b0;
        opReg  <= '0;
      end
    end else if (strobe.ackOnly) begin
      sizeF    <= '0;
      chunkRdy <= 1'b1;
    end else if (strobe.ackChunk) begin
      chunkRdy <= 1'b0;
    end else if (strobe.fail) begin
      errF     <= errCode;
      sizeF    <= '0;
      inProc   <= 1'b0;
      chunkRdy <= 1'b0;
      opReg    <= '0;
    end else if (strobe.finish || strobe.abort) begin
      opReg    <= '0;
      inProc   <= 1'b0;
      chunkRdy <= 1'b0;
    end else if (strobe.legDone) begin
      opReg <= '0;
    end
  end

  assign opWord   = opReg;
  assign ctrlWord = {4'b0, errF, chunkRdy, inProc, sizeF};

  always_comb begin
    rdData = '0;
    if (rdAddr == AddrW'(0)) rdData = opWord;
    if (rdAddr == AddrW'(1)) rdData = ctrlWord;
    for (int k = 0; k < ChunkWords; k++)
      if (rdAddr == AddrW'(WinBase + k)) rdData = win[k];
  end
endmodule

// File: rtl/chunk_mailbox.sv
module chunk_mailbox
  import chunk_mailbox_pkg::*;
#(
  parameter int ChunkWords = 4,
  parameter int RespWords  = 6,
  parameter int NumQueues  = 4,
  parameter int AddrW      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             legacyMode,
  input  logic             hostWrEn,
  input  logic [AddrW-1:0] hostAddr,
  input  logic [31:0]      hostWrData,
  output logic [31:0]      hostRdData
);
  mbStrobe_t   strobe;
  logic        wrOp, wrCtrl, errPending, noPayload, finalChunk;
  logic [31:0] opWord, ctrlWord;

  assign wrOp   = hostWrEn && hostAddr == AddrW'(0);
  assign wrCtrl = hostWrEn && hostAddr == AddrW'(1);

  mailbox_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrOp(wrOp), .wrCtrl(wrCtrl), .wrData(hostWrData),
    .legacyMode(legacyMode), .errPending(errPending), .noPayload(noPayload),
    .finalChunk(finalChunk), .strobe(strobe)
  );

  mailbox_datapath #(
    .ChunkWords(ChunkWords), .RespWords(RespWords),
    .NumQueues(NumQueues), .AddrW(AddrW)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(hostWrData),
    .rdAddr(hostAddr), .rdData(hostRdData), .opWord(opWord), .ctrlWord(ctrlWord),
    .errPending(errPending), .noPayload(noPayload), .finalChunk(finalChunk)
  );
endmodule

// File: rtl/chunk_mailbox_chk.sv
module chunk_mailbox_chk #(
  parameter int ChunkWords = 4,
  parameter int AddrW      = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             legacyMode,
  input logic             hostWrEn,
  input logic [AddrW-1:0] hostAddr,
  input logic [31:0]      hostWrData,
  input logic [31:0]      opWord,
  input logic [31:0]      ctrlWord
);
  logic opWrite, inProc, chunkRdy;
  logic [15:0] sizeF;
  logic [9:0]  errF;
  assign opWrite  = hostWrEn && hostAddr == AddrW'(0);
  assign inProc   = ctrlWord[16];
  assign chunkRdy = ctrlWord[17];
  assign sizeF    = ctrlWord[15:0];
  assign errF     = ctrlWord[27:18];

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (opWord == 32'd0 && opWrite && hostWrData[15:0] != 16'd0 && !legacyMode)
    |=> (opWord == $past(hostWrData) && inProc && !chunkRdy && errF == 10'd0));

  a_r3_size_bound: assert property (@(posedge clk) disable iff (!rstN)
    chunkRdy |-> sizeF <= 16'(ChunkWords));

  a_r5_final_clears_op: assert property (@(posedge clk) disable iff (!rstN)
    (chunkRdy && !inProc) |-> opWord == 32'd0);

  a_r8_error_idle: assert property (@(posedge clk) disable iff (!rstN)
    (errF != 10'd0) |-> (!inProc && !chunkRdy));

  a_r9_ignore_op: assert property (@(posedge clk) disable iff (!rstN)
    (opWord != 32'd0 && opWrite && hostWrData[15:0] != 16'd0)
    |=> (opWord == $past(opWord) || opWord == 32'd0));

  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    (opWord != 32'd0 && opWrite && hostWrData[15:0] == 16'd0)
    |=> (opWord == 32'd0 && !inProc && !chunkRdy));

  a_r11_legacy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opWord == 32'd0 && opWrite && hostWrData[15:0] != 16'd0 && legacyMode)
    |=> ##1 (opWord == 32'd0));
endmodule

bind chunk_mailbox chunk_mailbox_chk #(.ChunkWords(ChunkWords), .AddrW(AddrW)) uChk (
  .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .hostWrEn(hostWrEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .opWord(opWord), .ctrlWord(ctrlWord)
);

// File: tb/sim_chunk_mailbox.sv
`timescale 1ns/1ps
module sim_chunk_mailbox;
  localparam int CW = 4, RW = 6, NQ = 4, AW = 4;

  logic clk = 1'b0, rstN = 1'b0, legacyMode = 1'b0, hostWrEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  chunk_mailbox #(.ChunkWords(CW), .RespWords(RW), .NumQueues(NQ), .AddrW(AW)) u0 (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .hostWrEn(hostWrEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = AW'(a); hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    hostAddr = AW'(a);
    #1;
    v = hostRdData;
  endtask

  task automatic readState(input int q, input int len);
    logic [31:0] v, c;
    int tot, got, rem, n;
    wr(1, 32'(len));
    wr(0, {16'(q), 16'd2});
    rd(0, v); chk("R2 opcode readback", v, {16'(q), 16'd2});
    rd(1, c); chk("R2 ctrl after start", c & 32'h0FFF_0000, 32'h0001_0000);
    tot = (len < RW) ? len : RW;
    got = 0;
    forever begin
      @(negedge clk);
      rem = tot - got;
      n = (rem < CW) ? rem : CW;
      rd(1, c);
      chk("R3 chunk size", {16'd0, c[15:0]}, 32'(n));
      chk("R3 chunk ready", {31'd0, c[17]}, 32'd1);
      chk("R5 in-process vs final", {31'd0, c[16]}, {31'd0, rem > CW});
      for (int i = 0; i < CW; i++) begin
        rd(3 + i, v);
        chk("R3 window slot", v, (i < n) ? {16'(q), 16'hA000 + 16'(got + i)} : 32'd0);
      end
      got += int'(c[15:0]);
      if (rem <= CW) begin
        rd(0, v); chk("R5 command word cleared", v, 32'd0);
        chk("R6 total words", 32'(got), 32'(tot));
        break;
      end
      wr(1, c & ~32'h0002_0000);
      rd(1, c); chk("R4 ready cleared by ack", {31'd0, c[17]}, 32'd0);
    end
  endtask

  task automatic noPayload(input logic [15:0] op);
    logic [31:0] v, c;
    wr(1, 32'd0);
    wr(0, {16'd0, op});
    @(negedge clk);
    rd(1, c); chk("R7 payload-free ack", c, 32'h0003_0000);
    wr(1, 32'h0002_0000);
    rd(1, c); chk("R4 ack with ready set ignored", c, 32'h0003_0000);
    rd(0, v); chk("R4 command kept", v, {16'd0, op});
    wr(1, c & ~32'h0002_0000);
    rd(0, v); chk("R7 command cleared", v, 32'd0);
    rd(1, c); chk("R7 ctrl idle", c & 32'h0003_0000, 32'd0);
  endtask

  task automatic errCase(input logic [31:0] cmd, input logic [9:0] code);
    logic [31:0] v, c;
    wr(1, 32'd3);
    wr(0, cmd);
    @(negedge clk);
    rd(1, c); chk("R8 error code", {22'd0, c[27:18]}, {22'd0, code});
    chk("R8 flags clear", {30'd0, c[17:16]}, 32'd0);
    rd(0, v); chk("R8 command cleared", v, 32'd0);
  endtask

  task automatic runAll();
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 3 + CW; a++) begin
      rd(a, v); chk("R1 reset read", v, 32'd0);
    end
    for (int q = 0; q < NQ; q++)
      for (int len = 0; len <= 9; len++)
        readState(q, len);
    rd(2, v); chk("R3 reserved reads zero", v, 32'd0);
    rd(3 + CW, v); chk("R3 beyond window reads zero", v, 32'd0);
    noPayload(16'd1);
    noPayload(16'd3);
    noPayload(16'd4);
    errCase({16'd0, 16'd5}, 10'd1);
    errCase({16'd0, 16'hFFFF}, 10'd1);
    errCase({16'(NQ), 16'd2}, 10'd2);
    wr(1, 32'd0);
    rd(1, c); chk("R2 ctrl write clears error", c, 32'd0);
    // R9 then R10 during a multi-chunk read
    wr(1, 32'd8);
    wr(0, {16'd1, 16'd2});
    @(negedge clk);
    wr(0, 32'h0000_0003);
    rd(0, v); chk("R9 opcode write ignored", v, {16'd1, 16'd2});
    rd(1, c); chk("R9 chunk still pending", c, 32'h0003_0004);
    wr(0, 32'h0007_0000);
    rd(0, v); chk("R10 abort clears command", v, 32'd0);
    rd(1, c); chk("R10 abort clears flags", c & 32'h0003_0000, 32'd0);
    // R11 legacy mode
    wr(1, 32'd5);
    legacyMode = 1'b1;
    wr(0, 32'h0002_0004);
    rd(0, v); chk("R11 legacy opcode held", v, 32'h0002_0004);
    rd(1, c); chk("R11 ctrl untouched", c, 32'd5);
    @(negedge clk);
    rd(0, v); chk("R11 legacy opcode cleared", v, 32'd0);
    rd(1, c); chk("R11 ctrl still untouched", c, 32'd5);
    legacyMode = 1'b0;
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule